// File: doc/BRIEF.md
# Sprite Page DMA Sequencer

This block copies a full 256-byte page of memory into the sprite-memory data port while the processor is kept off the bus. The processor starts a copy by writing a page number to a trigger register. From the next cycle the block holds the processor with a halt signal and owns the shared address bus, data bus and write strobe. It first spends one or two alignment cycles. After that it alternates between reading a source byte and writing that byte to the fixed destination port. When the last byte has been written, it hands the bus back and pulses a done flag.

The bus never idles. Every cycle is either a read or a write. The alignment cycles are real reads at the processor's program-counter address. A free-running divide-by-two phase, `cycle_odd`, decides the alignment: source reads always fall on even cycles and destination writes always fall on odd cycles. A copy triggered in an even cycle stalls the processor for 513 cycles. A copy triggered in an odd cycle stalls it for 514.

The memory bus is a fixed-latency, single-cycle bus with no back-pressure. The read data returns within the cycle that presents the address, and a write completes in the cycle that asserts the strobe. For that reason the block has no valid/ready handshake. All of its pins are plain control and data signals.

Top module: `sprite_dma`

## Requirements
- R1: After reset, `halt` and `done` are 0 and `cycle_odd` is 0.
- R2: `cycle_odd` inverts on every clock cycle, during a copy as well as outside one.
- R3: A cycle with `cpu_we`=1 and `cpu_addr`=0x4014 while idle starts a copy. The source page is `cpu_wdata`, so source byte i sits at address {page, i}.
- R4: The first cycle after the trigger is a read (`bus_we`=0) at `cpu_pc`. If `cycle_odd` was 1 in the trigger cycle, a second read at `cpu_pc` follows it.
- R5: During a copy, every source read happens with `cycle_odd`=0 and every destination write happens with `cycle_odd`=1.
- R6: Exactly 256 read/write pairs are made, with i going up from 0 to 255. Each write puts the byte read in the previous cycle on `bus_wdata`, with `bus_we`=1, at address 0x2004.
- R7: `halt` is 0 in the trigger cycle. It is 1 for the next 513 cycles after an even trigger cycle, or 514 cycles after an odd one.
- R8: In the cycle after the write of byte 255, `halt` is 0 and `done` is 1 for exactly one cycle, and the bus again carries the processor's address.
- R9: Writes to 0x4014 made while a copy runs are ignored. The page and the address order do not change and no new copy starts.
- R10: While idle, the bus outputs repeat `cpu_addr`, `cpu_wdata` and `cpu_we`, and a write to any other address does not raise `halt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address for the current cycle |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Processor write strobe |
| cpu_pc | input | 16 | Processor program-counter address, used by the alignment reads |
| bus_rdata | input | 8 | Read data returned by memory for `bus_addr` |
| bus_addr | output | 16 | Shared bus address |
| bus_wdata | output | 8 | Shared bus write data |
| bus_we | output | 1 | Shared bus write strobe |
| halt | output | 1 | Holds the processor while a copy runs |
| done | output | 1 | One-cycle pulse when a copy has finished |
| cycle_odd | output | 1 | Divide-by-two cycle phase, 1 in odd cycles |

## Verification
The hardest case to reach is a trigger that lands in an odd cycle, because the trigger's phase depends only on how many cycles have passed since reset. The stimulus reads `cycle_odd` before each trigger and waits one cycle when needed, so every page in the sweep is copied once from each phase. A retrigger case keeps writing a different page to 0x4014 throughout one copy. The read addresses must still follow the first page, and the bus must be released after the expected count.

// File: rtl/sprdma_pkg.sv
package sprdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_FETCH,
    ST_STORE
  } dma_state_e;
endpackage

// File: rtl/sprdma_phase.sv
module sprdma_phase (
  input  logic clk,
  input  logic rst_n,
  output logic odd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) odd_q <= 1'b0;
    else        odd_q <= ~odd_q;
  end
endmodule

// File: rtl/sprdma_ctrl.sv
module sprdma_ctrl
  import sprdma_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter int              IDX_W     = 8,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              odd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] bus_rdata,
  output dma_state_e        state,
  output logic [ADDR_W-IDX_W-1:0] page,
  output logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] hold_data,
  output logic              done
);
  localparam int PAGE_W = ADDR_W - IDX_W;
  localparam logic [IDX_W-1:0] IDX_LAST = {IDX_W{1'b1}};

  logic trig;
  assign trig = (state == ST_IDLE) && cpu_we && (cpu_addr == TRIG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      page      <= '0;
      idx       <= '0;
      hold_data <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (trig) begin
            page  <= cpu_wdata[PAGE_W-1:0];
            idx   <= '0;
            state <= ST_ALIGN;
          end
        end
        ST_ALIGN: begin
          // leave alignment once the next cycle will be even
          if (odd) state <= ST_FETCH;
        end
        ST_FETCH: begin
          hold_data <= bus_rdata;
          state     <= ST_STORE;
        end
        ST_STORE: begin
          idx <= idx + 1'b1;
          if (idx == IDX_LAST) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_FETCH;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sprdma_busmux.sv
module sprdma_busmux
  import sprdma_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter int              IDX_W     = 8,
  parameter logic [ADDR_W-1:0] DEST_ADDR = 16'h2004
) (
  input  dma_state_e        state,
  input  logic [ADDR_W-IDX_W-1:0] page,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] hold_data,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_pc,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we
);
  always_comb begin
    bus_addr  = cpu_addr;
    bus_wdata = cpu_wdata;
    bus_we    = cpu_we;
    unique case (state)
      ST_ALIGN: begin
        bus_addr = cpu_pc;
        bus_we   = 1'b0;
      end
      ST_FETCH: begin
        bus_addr = {page, idx};
        bus_we   = 1'b0;
      end
      ST_STORE: begin
        bus_addr  = DEST_ADDR;
        bus_wdata = hold_data;
        bus_we    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
  import sprdma_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter int              IDX_W     = 8,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
  parameter logic [ADDR_W-1:0] DEST_ADDR = 16'h2004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_pc,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              halt,
  output logic              done,
  output logic              cycle_odd
);
  localparam int PAGE_W = ADDR_W - IDX_W;

  dma_state_e          st;
  logic [PAGE_W-1:0]   page;
  logic [IDX_W-1:0]    idx;
  logic [DATA_W-1:0]   hold_data;

  sprdma_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .odd_q (cycle_odd)
  );

  sprdma_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TRIG_ADDR(TRIG_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .odd       (cycle_odd),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .bus_rdata (bus_rdata),
    .state     (st),
    .page      (page),
    .idx       (idx),
    .hold_data (hold_data),
    .done      (done)
  );

  sprdma_busmux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .DEST_ADDR(DEST_ADDR)
  ) u_mux (
    .state     (st),
    .page      (page),
    .idx       (idx),
    .hold_data (hold_data),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .cpu_pc    (cpu_pc),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we)
  );

  assign halt = (st != ST_IDLE);
endmodule

// File: rtl/sprite_dma_chk.sv
module sprite_dma_chk #(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h4014,
  parameter logic [ADDR_W-1:0] DEST_ADDR = 16'h2004
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_pc,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              halt,
  input logic              done,
  input logic              cycle_odd
);
  // R2
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cycle_odd != $past(cycle_odd)));

  // R7
  halt_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && cpu_we && cpu_addr == TRIG_ADDR) |=> halt);

  // R4
  align_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt) |-> (!bus_we && bus_addr == cpu_pc));

  // R5
  write_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && bus_we) |-> (cycle_odd && bus_addr == DEST_ADDR));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!halt && $past(halt)));

  // R10
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !halt |-> (bus_addr == cpu_addr && bus_we == cpu_we));
endmodule

bind sprite_dma sprite_dma_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRIG_ADDR(TRIG_ADDR), .DEST_ADDR(DEST_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_we    (cpu_we),
  .cpu_pc    (cpu_pc),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .halt      (halt),
  .done      (done),
  .cycle_odd (cycle_odd)
);

// File: tb/test_sprite_dma.sv
module test_sprite_dma;
  localparam logic [15:0] TRIG = 16'h4014;
  localparam logic [15:0] DEST = 16'h2004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_wdata = 8'h00;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_pc = 16'h0000;
  logic [7:0]  bus_rdata;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_we, halt, done, cycle_odd;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign bus_rdata = mem_val(bus_addr);

  sprite_dma i_sprite_dma (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_pc(cpu_pc), .bus_rdata(bus_rdata),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .halt(halt), .done(done), .cycle_odd(cycle_odd)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic run_xfer(input logic [7:0] page, input bit want_odd, input bit poke);
    logic [15:0] pc;
    int align;
    int last;
    bit prev;
    pc = {page ^ 8'hC3, ~page};
    if (cycle_odd != want_odd) @(negedge clk);
    cpu_pc = pc; cpu_addr = TRIG; cpu_wdata = page; cpu_we = 1'b1;
    #1;
    chk(halt == 1'b0, "R7", {31'd0, halt}, 32'd0);
    prev  = cycle_odd;
    align = want_odd ? 2 : 1;
    last  = align + 512;
    for (int k = 1; k <= last + 2; k++) begin
      @(negedge clk);
      if (poke && k <= last) begin
        cpu_addr = TRIG; cpu_wdata = ~page; cpu_we = 1'b1;
      end else begin
        cpu_addr = pc; cpu_we = 1'b0;
      end
      #1;
      chk(cycle_odd != prev, "R2", {31'd0, cycle_odd}, {31'd0, ~prev});
      prev = cycle_odd;
      if (k <= align) begin
        chk(halt && !bus_we && bus_addr == pc, "R4", {15'd0, bus_we, bus_addr}, {16'd0, pc});
      end else if (k <= last) begin
        int j;
        int i;
        logic [15:0] src;
        j = k - align - 1;
        i = j / 2;
        src = {page, i[7:0]};
        chk(halt == 1'b1, "R7", {31'd0, halt}, 32'd1);
        chk(done == 1'b0, "R8", {31'd0, done}, 32'd0);
        if (j % 2 == 0) begin
          chk(bus_addr == src && !bus_we, poke ? "R9" : "R3",
              {15'd0, bus_we, bus_addr}, {16'd0, src});
          chk(cycle_odd == 1'b0, "R5", {31'd0, cycle_odd}, 32'd0);
        end else begin
          chk(bus_addr == DEST && bus_we && bus_wdata == mem_val(src), "R6",
              {7'd0, bus_we, bus_wdata, bus_addr}, {8'd1, mem_val(src), DEST});
          chk(cycle_odd == 1'b1, "R5", {31'd0, cycle_odd}, 32'd1);
        end
      end else if (k == last + 1) begin
        chk(!halt && done, "R8", {30'd0, halt, done}, 32'd1);
        chk(bus_addr == pc && !bus_we, "R8", {16'd0, bus_addr}, {16'd0, pc});
      end else begin
        chk(!done && !halt, poke ? "R9" : "R8", {30'd0, halt, done}, 32'd0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] pages [5];
    pages[0] = 8'h00; pages[1] = 8'h01; pages[2] = 8'h3C;
    pages[3] = 8'h80; pages[4] = 8'hFF;
    repeat (3) @(negedge clk);
    #1;
    chk(!halt && !done && !cycle_odd, "R1", {29'd0, halt, done, cycle_odd}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!halt && !done && !cycle_odd, "R1", {29'd0, halt, done, cycle_odd}, 32'd0);
    // R10: idle pass-through and non-trigger write
    @(negedge clk);
    cpu_addr = 16'h4015; cpu_wdata = 8'hA7; cpu_we = 1'b1;
    #1;
    chk(bus_addr == 16'h4015 && bus_wdata == 8'hA7 && bus_we, "R10",
        {7'd0, bus_we, bus_wdata, bus_addr}, {8'd1, 8'hA7, 16'h4015});
    @(negedge clk);
    cpu_we = 1'b0; cpu_addr = 16'h1234;
    #1;
    chk(!halt && bus_addr == 16'h1234 && !bus_we, "R10", {15'd0, halt, bus_addr}, 32'h1234);
    for (int p = 0; p < 5; p++) begin
      for (int ph = 0; ph < 2; ph++) begin
        @(negedge clk);
        run_xfer(pages[p], ph[0], 1'b0);
      end
    end
    for (int ph = 0; ph < 2; ph++) begin
      @(negedge clk);
      run_xfer(8'h5B, ph[0], 1'b1);
    end
    @(negedge clk);
    summary();
  end
endmodule